// File: doc/BRIEF.md
# Read/Write Bus Turnaround Arbiter

This block decides which direction the shared DRAM data bus serves. Reads are served by default. Writes collect in their own queue and are drained in batches. A batch starts when write occupancy reaches a high watermark. It ends only after a minimum number of write bursts has gone out, once occupancy has fallen to a low watermark. Each change of direction passes through a dedicated turnaround state. That state holds the bus idle for the read-to-write or the write-to-read gap before the new direction may issue.

The block sees only counts and handshakes. It receives the read, response and write queue occupancies, a per-burst grant pulse from the command issuer, and a flag saying that an incoming read's address matches a pending write. It answers with the bus state, a turnaround flag and accept/retry signals toward the two requestors. It also reports the number of bursts issued in the current direction since the last switch. Queue storage, address decoding and DRAM command generation belong to neighbouring blocks.

Top module: `bus_turn_arb`

## Requirements
- R1: `bus_state` is encoded 0 = serving reads, 1 = read-to-write turnaround, 2 = serving writes, 3 = write-to-read turnaround. It only moves 0→0/1, 1→1/2, 2→2/3 and 3→3/0. `dir_write` is 1 exactly in state 2, and `turn_busy` is 1 exactly in states 1 and 3.
- R2: In state 0, write occupancy at or above `WR_HI` moves the bus to state 1 on the next clock edge, even if reads are waiting. Occupancy below `WR_HI` with reads waiting keeps state 0.
- R3: In state 2 with reads waiting, the bus leaves for state 3 only when the registered write burst count is at least `MIN_WR` and write occupancy is at most `WR_LO`. Otherwise it stays in state 2.
- R4: State 1 lasts exactly `T_RTW` cycles and state 3 lasts exactly `T_WTR` cycles before the new serving state is entered.
- R5: A read request flagged as matching a pending write is accepted even when the read side is full, and `rd_from_wrq` is raised with it.
- R6: A rejected request sets a per-direction pending flag. `rd_retry`/`wr_retry` is a single-cycle pulse, raised in the first cycle in which that side is no longer full.
- R7: The read side is full when `rd_q_cnt + resp_q_cnt >= RD_DEPTH`. The write side is full when `wr_q_cnt >= WR_DEPTH`. A non-matching request to a full side is not accepted.
- R8: `rd_burst_cnt`/`wr_burst_cnt` count grants in states 0 and 2 respectively and saturate at their maximum. Both counts clear on the edge that enters a turnaround state, and grants during turnaround are ignored.
- R9: With no reads waiting and writes pending, state 0 moves to state 1. With no writes pending and reads waiting, state 2 moves to state 3 regardless of the burst count. With both queues empty the state holds.
- R10: After reset the state is 0 and both burst counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_q_cnt | input | $clog2(RD_DEPTH+1) | Read queue occupancy |
| resp_q_cnt | input | $clog2(RD_DEPTH+1) | Response queue occupancy, charged against read capacity |
| wr_q_cnt | input | $clog2(WR_DEPTH+1) | Write queue occupancy |
| rd_req | input | 1 | Incoming read request |
| rd_hit_wr | input | 1 | Incoming read matches a pending write address |
| wr_req | input | 1 | Incoming write request |
| burst_grant | input | 1 | One burst issued in the current direction |
| bus_state | output | 2 | Direction state (encoding in R1) |
| dir_write | output | 1 | Bus is serving writes |
| turn_busy | output | 1 | Turnaround in progress |
| rd_accept | output | 1 | Read request accepted this cycle |
| rd_from_wrq | output | 1 | Accepted read is served from the write queue |
| rd_retry | output | 1 | Retry pulse to a previously rejected reader |
| wr_accept | output | 1 | Write request accepted this cycle |
| wr_retry | output | 1 | Retry pulse to a previously rejected writer |
| rd_burst_cnt | output | CNT_W | Read bursts since last switch |
| wr_burst_cnt | output | CNT_W | Write bursts since last switch |

## Verification
The direction logic is driven through watermark crossings that tell the high-watermark trigger apart from the empty-queue trigger. Drain batches run with the burst count below and at `MIN_WR` while occupancy sits just above and at `WR_LO`, which shows that both conditions are needed to leave. Grants are applied during turnarounds to show they do not count, and both queues are emptied to show the bus holds. Admission is swept over every pair of read and response occupancy, with and without a write-queue match, and over every write occupancy. This separates the full-by-sum rule from the bypass rule. The retry pulses are then placed relative to the cycle in which space frees.

// File: rtl/bta_pkg.sv
package bta_pkg;
    typedef enum logic [1:0] {
        BUS_RD  = 2'd0,
        BUS_R2W = 2'd1,
        BUS_WR  = 2'd2,
        BUS_W2R = 2'd3
    } bus_dir_e;
endpackage

// File: rtl/bta_admit.sv
module bta_admit #(
    parameter int DEPTH = 4,
    parameter int OW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          bypass_i,
    input  logic [OW-1:0] occ_i,
    output logic          accept_o,
    output logic          retry_o
);
    typedef struct packed {
        logic pend;
    } adm_s;

    adm_s st_d, st_q;
    logic full;

    always_comb begin
        full     = occ_i >= OW'(DEPTH);
        accept_o = req_i && (bypass_i || !full);
        retry_o  = st_q.pend && !full;
        st_d.pend = (st_q.pend && full) || (req_i && !accept_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: retry is a single-cycle pulse
    p_retry_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |=> !retry_o);
endmodule

// File: rtl/bta_burst_ctr.sv
module bta_burst_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_s;

    ctr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)                        st_d.cnt = '0;
        else if (inc_i && st_q.cnt != CMAX) st_d.cnt = st_q.cnt + 1'b1;
        cnt_o = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bta_dir_fsm.sv
module bta_dir_fsm
    import bta_pkg::*;
#(
    parameter int RCW    = 3,
    parameter int WCW    = 4,
    parameter int CNT_W  = 8,
    parameter int WR_HI  = 6,
    parameter int WR_LO  = 2,
    parameter int MIN_WR = 3,
    parameter int T_RTW  = 2,
    parameter int T_WTR  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RCW-1:0]   rd_occ_i,
    input  logic [WCW-1:0]   wr_occ_i,
    input  logic             grant_i,
    input  logic [CNT_W-1:0] wr_cnt_i,
    output bus_dir_e         state_o,
    output logic             rd_inc_o,
    output logic             wr_inc_o,
    output logic             clr_o
);
    localparam int TMAX = (T_RTW > T_WTR) ? T_RTW : T_WTR;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        bus_dir_e      state;
        logic [TW-1:0] tmr;
    } fsm_s;

    fsm_s st_d, st_q;
    logic rd_wait, wr_wait, leave_rd, leave_wr;

    always_comb begin
        rd_wait  = rd_occ_i != '0;
        wr_wait  = wr_occ_i != '0;
        leave_rd = wr_wait && ((wr_occ_i >= WCW'(WR_HI)) || !rd_wait);
        leave_wr = rd_wait && (!wr_wait ||
                   ((wr_cnt_i >= CNT_W'(MIN_WR)) && (wr_occ_i <= WCW'(WR_LO))));
        st_d     = st_q;
        rd_inc_o = 1'b0;
        wr_inc_o = 1'b0;
        clr_o    = 1'b0;
        unique case (st_q.state)
            BUS_RD: begin
                rd_inc_o = grant_i;
                if (leave_rd) begin
                    st_d.state = BUS_R2W;
                    st_d.tmr   = TW'(T_RTW);
                    clr_o      = 1'b1;
                end
            end
            BUS_R2W: begin
                if (st_q.tmr <= TW'(1)) st_d.state = BUS_WR;
                else                    st_d.tmr   = st_q.tmr - 1'b1;
            end
            BUS_WR: begin
                wr_inc_o = grant_i;
                if (leave_wr) begin
                    st_d.state = BUS_W2R;
                    st_d.tmr   = TW'(T_WTR);
                    clr_o      = 1'b1;
                end
            end
            BUS_W2R: begin
                if (st_q.tmr <= TW'(1)) st_d.state = BUS_RD;
                else                    st_d.tmr   = st_q.tmr - 1'b1;
            end
            default: st_d.state = BUS_RD;
        endcase
        state_o = st_q.state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= BUS_RD;
            st_q.tmr   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: legal successor states
    p_seq_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.state == BUS_RD |=> (st_q.state == BUS_RD || st_q.state == BUS_R2W));
    p_seq_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.state == BUS_WR |=> (st_q.state == BUS_WR || st_q.state == BUS_W2R));
    // R2: high watermark starts a drain
    p_hi_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == BUS_RD && wr_occ_i >= WCW'(WR_HI)) |=> st_q.state == BUS_R2W);
    // R3: no early exit before the minimum batch
    p_min_batch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == BUS_WR && wr_occ_i != '0 && wr_cnt_i < CNT_W'(MIN_WR))
        |=> st_q.state == BUS_WR);
endmodule

// File: rtl/bus_turn_arb.sv
module bus_turn_arb
    import bta_pkg::*;
#(
    parameter int RD_DEPTH = 4,
    parameter int WR_DEPTH = 8,
    parameter int WR_HI    = 6,
    parameter int WR_LO    = 2,
    parameter int MIN_WR   = 3,
    parameter int T_RTW    = 2,
    parameter int T_WTR    = 3,
    parameter int CNT_W    = 8,
    localparam int RCW     = $clog2(RD_DEPTH + 1),
    localparam int WCW     = $clog2(WR_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RCW-1:0]   rd_q_cnt,
    input  logic [RCW-1:0]   resp_q_cnt,
    input  logic [WCW-1:0]   wr_q_cnt,
    input  logic             rd_req,
    input  logic             rd_hit_wr,
    input  logic             wr_req,
    input  logic             burst_grant,
    output logic [1:0]       bus_state,
    output logic             dir_write,
    output logic             turn_busy,
    output logic             rd_accept,
    output logic             rd_from_wrq,
    output logic             rd_retry,
    output logic             wr_accept,
    output logic             wr_retry,
    output logic [CNT_W-1:0] rd_burst_cnt,
    output logic [CNT_W-1:0] wr_burst_cnt
);
    bus_dir_e         state;
    logic             rd_inc, wr_inc, clr;
    logic [RCW:0]     rd_occ;
    logic [CNT_W-1:0] cnt [2];
    logic [1:0]       inc_v;

    assign rd_occ = {1'b0, rd_q_cnt} + {1'b0, resp_q_cnt};
    assign inc_v  = {wr_inc, rd_inc};

    bta_dir_fsm #(
        .RCW(RCW), .WCW(WCW), .CNT_W(CNT_W), .WR_HI(WR_HI), .WR_LO(WR_LO),
        .MIN_WR(MIN_WR), .T_RTW(T_RTW), .T_WTR(T_WTR)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_occ_i(rd_q_cnt), .wr_occ_i(wr_q_cnt),
        .grant_i(burst_grant), .wr_cnt_i(cnt[1]), .state_o(state),
        .rd_inc_o(rd_inc), .wr_inc_o(wr_inc), .clr_o(clr)
    );

    for (genvar g = 0; g < 2; g++) begin : g_ctr
        bta_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(inc_v[g]), .cnt_o(cnt[g])
        );
    end

    bta_admit #(.DEPTH(RD_DEPTH), .OW(RCW + 1)) u_rd_adm (
        .clk(clk), .rst_n(rst_n), .req_i(rd_req), .bypass_i(rd_hit_wr),
        .occ_i(rd_occ), .accept_o(rd_accept), .retry_o(rd_retry)
    );

    bta_admit #(.DEPTH(WR_DEPTH), .OW(WCW)) u_wr_adm (
        .clk(clk), .rst_n(rst_n), .req_i(wr_req), .bypass_i(1'b0),
        .occ_i(wr_q_cnt), .accept_o(wr_accept), .retry_o(wr_retry)
    );

    assign bus_state    = state;
    assign dir_write    = state == BUS_WR;
    assign turn_busy    = state == BUS_R2W || state == BUS_W2R;
    assign rd_from_wrq  = rd_req && rd_hit_wr;
    assign rd_burst_cnt = cnt[0];
    assign wr_burst_cnt = cnt[1];

    // R8: counters are empty throughout a turnaround
    p_cnt_zero_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        turn_busy |-> (rd_burst_cnt == '0 && wr_burst_cnt == '0));
    // R5: matching reads always admitted
    p_fwd_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_from_wrq |-> rd_accept);
endmodule

// File: tb/tb_bus_turn_arb.sv
`timescale 1ns/1ps
module tb_bus_turn_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rd_q_cnt = '0, resp_q_cnt = '0;
    logic [3:0] wr_q_cnt = '0;
    logic       rd_req = 0, rd_hit_wr = 0, wr_req = 0, burst_grant = 0;
    logic [1:0] bus_state;
    logic       dir_write, turn_busy, rd_accept, rd_from_wrq, rd_retry, wr_accept, wr_retry;
    logic [7:0] rd_burst_cnt, wr_burst_cnt;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    bus_turn_arb #(.RD_DEPTH(4), .WR_DEPTH(8), .WR_HI(6), .WR_LO(2), .MIN_WR(3),
                   .T_RTW(2), .T_WTR(3), .CNT_W(8)) dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_state(input string tag, input int st, input int rc, input int wc);
        chk({tag, " state"}, bus_state, st);
        chk({tag, " dir_write"}, dir_write, st == 2);
        chk({tag, " turn_busy"}, turn_busy, st == 1 || st == 3);
        chk({tag, " rd_cnt"}, rd_burst_cnt, rc);
        chk({tag, " wr_cnt"}, wr_burst_cnt, wc);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        chk_state("R10 reset", 0, 0, 0);

        // R2: below and at high watermark
        rd_q_cnt = 3; wr_q_cnt = 5; step(1);
        chk_state("R2 below hi", 0, 0, 0);
        wr_q_cnt = 6; step(1);
        chk_state("R2 at hi", 1, 0, 0);
        step(1); chk_state("R4 rtw hold", 1, 0, 0);
        step(1); chk_state("R4 rtw done", 2, 0, 0);

        // R3: minimum batch and low watermark
        wr_q_cnt = 2; burst_grant = 1;
        step(1); chk_state("R8 wr grant1", 2, 0, 1);
        step(1); chk_state("R3 below min", 2, 0, 2);
        wr_q_cnt = 3;
        step(1); chk_state("R3 above lo", 2, 0, 3);
        burst_grant = 0;
        step(1); chk_state("R3 hold above lo", 2, 0, 3);
        wr_q_cnt = 2; burst_grant = 1;
        step(1); chk_state("R3 leave", 3, 0, 0);
        step(1); chk_state("R8 grant in turn", 3, 0, 0);
        step(1); chk_state("R4 wtr hold", 3, 0, 0);
        step(1); chk_state("R4 wtr done", 0, 0, 0);
        step(1); chk_state("R8 rd grant", 0, 1, 0);
        burst_grant = 0;

        // R9: single non-empty queue and both empty
        rd_q_cnt = 0; wr_q_cnt = 1;
        step(1); chk_state("R9 only writes", 1, 0, 0);
        step(2); chk_state("R9 in write", 2, 0, 0);
        rd_q_cnt = 1; wr_q_cnt = 0;
        step(1); chk_state("R9 only reads", 3, 0, 0);
        step(3); chk_state("R9 back read", 0, 0, 0);
        rd_q_cnt = 0;
        step(2); chk_state("R9 both empty", 0, 0, 0);

        // R5/R7: read admission sweep
        rd_req = 1;
        for (int r = 0; r <= 4; r++)
            for (int p = 0; p <= 4; p++)
                for (int h = 0; h <= 1; h++) begin
                    rd_q_cnt = 3'(r); resp_q_cnt = 3'(p); rd_hit_wr = h[0];
                    #1;
                    chk($sformatf("R7 rd accept r=%0d p=%0d h=%0d", r, p, h),
                        rd_accept, (h == 1) || (r + p < 4));
                    chk("R5 from wrq", rd_from_wrq, h);
                    step(1);
                end
        rd_req = 0; rd_hit_wr = 0; rd_q_cnt = 0; resp_q_cnt = 0;
        step(2);

        // R7: write admission sweep
        wr_req = 1;
        for (int w = 0; w <= 8; w++) begin
            wr_q_cnt = 4'(w);
            #1;
            chk($sformatf("R7 wr accept w=%0d", w), wr_accept, w < 8);
            step(1);
        end
        wr_req = 0; wr_q_cnt = 0;
        step(2);

        // R6: read retry
        rd_q_cnt = 2; resp_q_cnt = 2; rd_req = 1;
        #1; chk("R7 rd full by sum", rd_accept, 0);
        step(1); rd_req = 0;
        #1; chk("R6 rd no retry while full", rd_retry, 0);
        step(1);
        resp_q_cnt = 1;
        #1; chk("R6 rd retry pulse", rd_retry, 1);
        step(1);
        chk("R6 rd retry once", rd_retry, 0);

        // R6: write retry
        wr_q_cnt = 8; wr_req = 1;
        step(1); wr_req = 0;
        #1; chk("R6 wr no retry while full", wr_retry, 0);
        step(1);
        wr_q_cnt = 7;
        #1; chk("R6 wr retry pulse", wr_retry, 1);
        step(1);
        chk("R6 wr retry once", wr_retry, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule